// File: doc/BRIEF.md
# Policy-Selectable Memory Request Scheduler

This block sits between the cache-miss path of a processor's bus interface and the DRAM controller. Requests arrive on a valid/ready enqueue port. Each request carries a bank, a row, a column and a write flag, and the block holds it in a small queue. Whenever the issue port is ready, the block picks one queued request to send downstream. Three policies are available for that choice. Plain arrival order keeps the original sequence. Reads-first lets a read overtake writes, which helps latency. Same-row-first serves the queued requests that hit the bank and row issued last, which cuts row activations and so saves activation and precharge energy.

Within any policy the oldest eligible entry wins a tie. When no entry falls in the preferred class, the oldest entry issues. A read never overtakes an older queued write to the identical bank, row and column. The policy input is taken only while the queue is empty, so a policy change never takes effect partway through a batch of queued requests. DRAM timing and data movement belong to other blocks.

Top module: `mem_req_sched`

## Requirements
- R1: After reset the queue is empty, so `iss_valid` is 0 and `enq_ready` is 1. The same-row history is cleared.
- R2: With DEPTH entries held, `enq_ready` is 0. A request offered in that state is not stored, and exactly DEPTH requests drain afterwards.
- R3: With policy code 0 (arrival order), requests issue strictly in the order they were accepted.
- R4: With policy code 1 (reads first), the oldest eligible read (`enq_write`=0) issues before any write.
- R5: With policy code 2 (same row first), the oldest entry whose bank and row both equal those of the last issued request is chosen. Before any request has issued since reset, no entry matches.
- R6: When no entry is eligible for the preferred class, the oldest queued entry issues.
- R7: A read is never issued while an older write to the same bank, row and column is still queued.
- R8: `policy_sel` is sampled only in cycles where the queue is empty. A change while requests are queued has no effect on their order. Code 3 behaves as code 0.
- R9: An enqueue and an issue in the same cycle both take effect. The new request lands behind the remaining entries.
- R10: While `iss_valid` is 1 and `iss_ready` is 0, `iss_valid` stays 1. If nothing is enqueued, the offered request does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| policy_sel | input | 2 | Policy code: 0 arrival order, 1 reads first, 2 same row first, 3 as 0 |
| enq_valid | input | 1 | Request offered |
| enq_ready | output | 1 | Queue can accept a request |
| enq_bank | input | BANK_W | Request bank |
| enq_row | input | ROW_W | Request row |
| enq_col | input | COL_W | Request column |
| enq_write | input | 1 | 1 for write, 0 for read or fetch |
| iss_valid | output | 1 | A request is offered downstream |
| iss_ready | input | 1 | Downstream accepts the offered request |
| iss_bank | output | BANK_W | Issued bank |
| iss_row | output | ROW_W | Issued row |
| iss_col | output | COL_W | Issued column |
| iss_write | output | 1 | Issued write flag |

## Verification
The bench targets the read-after-write case under reads-first. A design without the hazard check would send the younger read to the same address ahead of its write. It also checks that a bank mismatch defeats a row match under same-row-first; a design comparing rows only would interleave banks. It changes the policy mid-batch, which a design sampling the policy every cycle would follow. It offers a request to a full queue, which a design with a bad full flag would drop or overwrite. It also overlaps enqueue with issue, where a wrong compaction step would lose or duplicate an entry.

// File: rtl/mrs_pkg.sv
package mrs_pkg;

   typedef enum logic [1:0] {
      POL_FCFS  = 2'd0,
      POL_READS = 2'd1,
      POL_ROW   = 2'd2,
      POL_RSVD  = 2'd3
   } mrs_policy_e;

endpackage

// File: rtl/mrs_queue.sv
module mrs_queue #(
   parameter int DEPTH = 8,
   parameter int ENT_W = 28
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         push,
   input  logic [ENT_W-1:0]             push_ent,
   input  logic                         pop,
   input  logic [$clog2(DEPTH)-1:0]     pop_idx,
   output logic [ENT_W-1:0]             ent [DEPTH],
   output logic [$clog2(DEPTH+1)-1:0]   cnt,
   output logic                         full
);
   localparam int IDX_W = $clog2(DEPTH);
   localparam int CNT_W = $clog2(DEPTH+1);

   logic [ENT_W-1:0] mem [DEPTH];
   logic [ENT_W-1:0] shf [DEPTH];
   logic [ENT_W-1:0] nxt [DEPTH];
   logic [CNT_W-1:0] cnt_mid;

   // collapse the slot removed by an issue: everything above moves down one
   for (genvar i = 0; i < DEPTH; i++) begin : g_shift
      if (i == DEPTH-1) begin : g_top
         assign shf[i] = (pop && (pop_idx <= IDX_W'(i))) ? '0 : mem[i];
      end else begin : g_mid
         assign shf[i] = (pop && (IDX_W'(i) >= pop_idx)) ? mem[i+1] : mem[i];
      end
   end

   assign cnt_mid = cnt - CNT_W'(pop);

   always_comb begin
      nxt = shf;
      if (push) nxt[cnt_mid[IDX_W-1:0]] = push_ent;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else begin
         cnt <= cnt_mid + CNT_W'(push);
         mem <= nxt;
      end
   end

   assign ent  = mem;
   assign full = (cnt == CNT_W'(DEPTH));

endmodule

// File: rtl/mrs_openrow.sv
module mrs_openrow #(
   parameter int BANK_W = 3,
   parameter int ROW_W  = 14
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fire,
   input  logic [BANK_W-1:0] fire_bank,
   input  logic [ROW_W-1:0]  fire_row,
   output logic              last_vld,
   output logic [BANK_W-1:0] last_bank,
   output logic [ROW_W-1:0]  last_row
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         last_vld  <= 1'b0;
         last_bank <= '0;
         last_row  <= '0;
      end else if (fire) begin
         last_vld  <= 1'b1;
         last_bank <= fire_bank;
         last_row  <= fire_row;
      end
   end
endmodule

// File: rtl/mrs_pick.sv
module mrs_pick
   import mrs_pkg::*;
#(
   parameter int DEPTH  = 8,
   parameter int BANK_W = 3,
   parameter int ROW_W  = 14,
   parameter int COL_W  = 10
) (
   input  logic [BANK_W+ROW_W+COL_W:0]  ent [DEPTH],
   input  logic [$clog2(DEPTH+1)-1:0]   cnt,
   input  mrs_policy_e                  policy,
   input  logic                         last_vld,
   input  logic [BANK_W-1:0]            last_bank,
   input  logic [ROW_W-1:0]             last_row,
   output logic [$clog2(DEPTH)-1:0]     sel
);
   localparam int IDX_W   = $clog2(DEPTH);
   localparam int CNT_W   = $clog2(DEPTH+1);
   localparam int ROW_LSB = COL_W;
   localparam int BNK_LSB = COL_W + ROW_W;
   localparam int WR_BIT  = COL_W + ROW_W + BANK_W;

   logic [DEPTH-1:0] vld;
   logic [DEPTH-1:0] cand;

   for (genvar i = 0; i < DEPTH; i++) begin : g_ent
      logic              wr;
      logic [BANK_W-1:0] bnk;
      logic [ROW_W-1:0]  row;
      logic              haz;
      logic              pref;

      assign vld[i] = (CNT_W'(i) < cnt);
      assign wr     = ent[i][WR_BIT];
      assign bnk    = ent[i][BNK_LSB +: BANK_W];
      assign row    = ent[i][ROW_LSB +: ROW_W];

      // a read is held back by any older queued write to the same address
      always_comb begin
         haz = 1'b0;
         for (int j = 0; j < i; j++) begin
            if ((CNT_W'(j) < cnt) && ent[j][WR_BIT] &&
                (ent[j][WR_BIT-1:0] == ent[i][WR_BIT-1:0]))
               haz = 1'b1;
         end
         if (wr) haz = 1'b0;
      end

      always_comb begin
         unique case (policy)
            POL_READS: pref = !wr;
            POL_ROW:   pref = last_vld && (bnk == last_bank) && (row == last_row);
            default:   pref = 1'b0;
         endcase
      end

      assign cand[i] = vld[i] && pref && !haz;
   end

   // oldest preferred entry, else the head of the queue
   always_comb begin
      logic found;
      found = 1'b0;
      sel   = '0;
      for (int k = 0; k < DEPTH; k++) begin
         if (cand[k] && !found) begin
            sel   = IDX_W'(k);
            found = 1'b1;
         end
      end
   end

endmodule

// File: rtl/mem_req_sched.sv
module mem_req_sched
   import mrs_pkg::*;
#(
   parameter int DEPTH  = 8,
   parameter int BANK_W = 3,
   parameter int ROW_W  = 14,
   parameter int COL_W  = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        policy_sel,
   input  logic              enq_valid,
   output logic              enq_ready,
   input  logic [BANK_W-1:0] enq_bank,
   input  logic [ROW_W-1:0]  enq_row,
   input  logic [COL_W-1:0]  enq_col,
   input  logic              enq_write,
   output logic              iss_valid,
   input  logic              iss_ready,
   output logic [BANK_W-1:0] iss_bank,
   output logic [ROW_W-1:0]  iss_row,
   output logic [COL_W-1:0]  iss_col,
   output logic              iss_write
);
   localparam int IDX_W = $clog2(DEPTH);
   localparam int CNT_W = $clog2(DEPTH+1);
   localparam int ENT_W = 1 + BANK_W + ROW_W + COL_W;

   if (!(DEPTH == 8 || DEPTH == 32)) begin : g_bad_depth
      $error("mem_req_sched: DEPTH must be 8 or 32");
   end
   if (BANK_W < 1 || ROW_W < 1 || COL_W < 1) begin : g_bad_width
      $error("mem_req_sched: field widths must be at least 1");
   end

   logic [ENT_W-1:0] ent [DEPTH];
   logic [CNT_W-1:0] cnt;
   logic             full;
   logic [IDX_W-1:0] pick_idx;
   logic             push;
   logic             pop;
   mrs_policy_e      pol_q;
   logic             last_vld;
   logic [BANK_W-1:0] last_bank;
   logic [ROW_W-1:0]  last_row;
   logic [ENT_W-1:0] head;

   assign enq_ready = !full;
   assign push      = enq_valid && enq_ready;
   assign iss_valid = (cnt != '0);
   assign pop       = iss_valid && iss_ready;

   always_ff @(posedge clk) begin
      if (!rst_n)          pol_q <= POL_FCFS;
      else if (cnt == '0)  pol_q <= mrs_policy_e'(policy_sel);
   end

   mrs_queue #(.DEPTH(DEPTH), .ENT_W(ENT_W)) u_queue (
      .clk      (clk),
      .rst_n    (rst_n),
      .push     (push),
      .push_ent ({enq_write, enq_bank, enq_row, enq_col}),
      .pop      (pop),
      .pop_idx  (pick_idx),
      .ent      (ent),
      .cnt      (cnt),
      .full     (full)
   );

   mrs_pick #(.DEPTH(DEPTH), .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W)) u_pick (
      .ent       (ent),
      .cnt       (cnt),
      .policy    (pol_q),
      .last_vld  (last_vld),
      .last_bank (last_bank),
      .last_row  (last_row),
      .sel       (pick_idx)
   );

   mrs_openrow #(.BANK_W(BANK_W), .ROW_W(ROW_W)) u_openrow (
      .clk       (clk),
      .rst_n     (rst_n),
      .fire      (pop),
      .fire_bank (iss_bank),
      .fire_row  (iss_row),
      .last_vld  (last_vld),
      .last_bank (last_bank),
      .last_row  (last_row)
   );

   assign head = ent[pick_idx];
   assign {iss_write, iss_bank, iss_row, iss_col} = head;

endmodule

// File: rtl/mrs_sched_chk.sv
module mrs_sched_chk
   import mrs_pkg::*;
#(
   parameter int DEPTH  = 8,
   parameter int BANK_W = 3,
   parameter int ROW_W  = 14,
   parameter int COL_W  = 10
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       enq_valid,
   input logic                       enq_ready,
   input logic                       iss_valid,
   input logic                       iss_ready,
   input logic [BANK_W-1:0]          iss_bank,
   input logic [ROW_W-1:0]           iss_row,
   input logic [COL_W-1:0]           iss_col,
   input logic                       iss_write,
   input logic [$clog2(DEPTH+1)-1:0] cnt,
   input logic [$clog2(DEPTH)-1:0]   pick_idx,
   input mrs_policy_e                pol_q,
   input logic                       last_vld,
   input logic [BANK_W-1:0]          last_bank,
   input logic [ROW_W-1:0]           last_row
);
   localparam int CNT_W = $clog2(DEPTH+1);

   p_full_refuse_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == CNT_W'(DEPTH)) |-> !enq_ready);

   p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CNT_W'(DEPTH));

   p_fcfs_head_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_valid && (pol_q == POL_FCFS || pol_q == POL_RSVD)) |-> (pick_idx == '0));

   p_track_row_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_valid && iss_ready) |=>
         (last_vld && last_bank == $past(iss_bank) && last_row == $past(iss_row)));

   p_pick_in_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
      iss_valid |-> (CNT_W'(pick_idx) < cnt));

   p_policy_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt != '0) |=> $stable(pol_q));

   p_stall_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_valid && !iss_ready && !(enq_valid && enq_ready)) |=>
         (iss_valid && $stable(iss_bank) && $stable(iss_row) &&
          $stable(iss_col) && $stable(iss_write)));

endmodule

bind mem_req_sched mrs_sched_chk #(
   .DEPTH(DEPTH), .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W)
) u_chk (.*);

// File: tb/tb_mem_req_sched.sv
`timescale 1ns/1ps
module tb_mem_req_sched;
   localparam int DEPTH  = 8;
   localparam int BANK_W = 3;
   localparam int ROW_W  = 14;
   localparam int COL_W  = 10;
   localparam int NV     = 8;

   logic              clk = 1'b0;
   logic              rst_n;
   logic [1:0]        policy_sel;
   logic              enq_valid;
   logic              enq_ready;
   logic [BANK_W-1:0] enq_bank;
   logic [ROW_W-1:0]  enq_row;
   logic [COL_W-1:0]  enq_col;
   logic              enq_write;
   logic              iss_valid;
   logic              iss_ready;
   logic [BANK_W-1:0] iss_bank;
   logic [ROW_W-1:0]  iss_row;
   logic [COL_W-1:0]  iss_col;
   logic              iss_write;

   int errors = 0;
   int checks = 0;

   always #4 clk = ~clk;

   mem_req_sched #(.DEPTH(DEPTH), .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W)) dut (.*);

   // request code: {write, bank[2:0], row[3:0], col[3:0]}
   function automatic logic [11:0] rq(input int w, input int b, input int r, input int c);
      return {w[0], b[2:0], r[3:0], c[3:0]};
   endfunction

   // vector: {policy[1:0], req0, req1, req2, req3, order (first issue in [7:6])}
   localparam logic [57:0] VEC [NV] = '{
      {2'd0, rq(1,0,1,0), rq(0,0,2,0), rq(0,0,1,4), rq(1,0,3,1), 8'b00_01_10_11},
      {2'd1, rq(1,0,1,0), rq(0,0,2,0), rq(0,0,1,4), rq(1,0,3,1), 8'b01_10_00_11},
      {2'd2, rq(1,0,1,0), rq(0,0,2,0), rq(0,0,1,4), rq(1,0,3,1), 8'b00_10_01_11},
      {2'd2, rq(0,0,5,0), rq(0,1,5,1), rq(0,0,5,2), rq(0,1,5,3), 8'b00_10_01_11},
      {2'd1, rq(1,0,2,3), rq(0,0,2,3), rq(0,0,4,0), rq(1,0,4,1), 8'b10_00_01_11},
      {2'd3, rq(1,0,1,0), rq(0,0,2,0), rq(0,0,1,4), rq(1,0,3,1), 8'b00_01_10_11},
      {2'd1, rq(1,0,1,0), rq(1,0,2,1), rq(1,1,1,2), rq(1,0,3,3), 8'b00_01_10_11},
      {2'd2, rq(0,2,9,0), rq(0,2,8,1), rq(1,2,8,2), rq(0,2,9,3), 8'b00_11_01_10}
   };
   localparam string VTAG [NV] = '{
      "R3", "R4", "R5 R6", "R5", "R4 R7", "R8", "R4 R6", "R5 R6"
   };

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      enq_valid = 1'b0; iss_ready = 1'b0;
      enq_bank = '0; enq_row = '0; enq_col = '0; enq_write = 1'b0;
      repeat (2) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic enq(input logic [11:0] r);
      enq_valid = 1'b1;
      enq_write = r[11];
      enq_bank  = r[10:8];
      enq_row   = ROW_W'(r[7:4]);
      enq_col   = COL_W'(r[3:0]);
      @(posedge clk);
      @(negedge clk);
      enq_valid = 1'b0;
   endtask

   // sample the offered request, then let it go
   task automatic take(input logic [11:0] exp, input string tag);
      logic [11:0] act;
      iss_ready = 1'b1;
      act = {iss_write, iss_bank, iss_row[3:0], iss_col[3:0]};
      chk(iss_valid && act == exp && iss_row[ROW_W-1:4] == '0, tag, act, exp);
      @(posedge clk);
      @(negedge clk);
      iss_ready = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      policy_sel = 2'd0;
      do_reset();
      // R1: reset state
      chk(!iss_valid, "R1 iss_valid", iss_valid, 0);
      chk(enq_ready, "R1 enq_ready", enq_ready, 1);

      // table of policy scenarios
      for (int v = 0; v < NV; v++) begin
         logic [57:0] e;
         e = VEC[v];
         policy_sel = e[57:56];
         do_reset();
         for (int k = 0; k < 4; k++) enq(e[55-12*k -: 12]);
         for (int k = 0; k < 4; k++) begin
            int o;
            o = int'(e[7-2*k -: 2]);
            take(e[55-12*o -: 12], VTAG[v]);
         end
         chk(!iss_valid, {VTAG[v], " drained"}, iss_valid, 0);
      end

      // R2: fill, offer one more, drain exactly DEPTH
      policy_sel = 2'd0;
      do_reset();
      for (int k = 0; k < DEPTH; k++) enq(rq(0, 1, 2, k));
      chk(!enq_ready, "R2 full refuses", enq_ready, 0);
      enq(rq(0, 1, 2, 15));
      for (int k = 0; k < DEPTH; k++) take(rq(0, 1, 2, k), "R2 R3 drain");
      chk(!iss_valid, "R2 no extra entry", iss_valid, 0);

      // R8: policy change while queued is ignored
      policy_sel = 2'd0;
      do_reset();
      enq(rq(1, 0, 1, 0));
      policy_sel = 2'd1;
      enq(rq(0, 0, 2, 1));
      take(rq(1, 0, 1, 0), "R8 held policy");
      take(rq(0, 0, 2, 1), "R8 held policy");

      // R9: enqueue and issue in one cycle; R10: stall holds the offer
      policy_sel = 2'd0;
      do_reset();
      enq(rq(0, 3, 4, 1));
      enq_valid = 1'b1; enq_write = 1'b1; enq_bank = 3'd3;
      enq_row = ROW_W'(6); enq_col = COL_W'(2);
      take(rq(0, 3, 4, 1), "R9 same-cycle issue");
      enq_valid = 1'b0;
      chk(iss_valid && iss_col == COL_W'(2) && iss_write, "R9 new entry kept", iss_col, 2);
      repeat (3) @(negedge clk);
      chk(iss_valid, "R10 valid held", iss_valid, 1);
      chk(iss_col == COL_W'(2) && iss_row == ROW_W'(6), "R10 offer held", iss_col, 2);
      take(rq(1, 3, 6, 2), "R10 release");
      chk(!iss_valid, "R9 empty after", iss_valid, 0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule